// File: doc/BRIEF.md
# Fixed-point x^y powering unit

This block raises a positive fixed-point operand to a fixed-point power by rewriting the task as e^(y·ln x). It reuses one iterative hyperbolic rotation engine for two passes. The engine's iteration schedule adds extra steps with non-positive indices, which widens its convergence range.

The first pass runs the engine in vectoring mode. It is loaded with x+1 as the horizontal coordinate, x-1 as the vertical one and a zero angle, and it leaves half the natural logarithm of x in its angle register. The controller doubles that value with a one-bit left shift. A saturating fixed-point multiplier then scales it by y. The second pass runs the engine in rotation mode. Both coordinates start at the supplied inverse gain constant and the angle starts at y·ln x, so the horizontal coordinate ends at x^y. An output register captures the result and raises a one-cycle done pulse.

All operands, intermediate values and the result share one two's-complement format of B bits with FW fractional bits. An operand x of zero or below is rejected at once with an error flag and a zero result. The caller must keep |y·ln x| inside the engine's convergence bound, which is about 12.43 for M=5.

Top module: `xpow_powering`

## Requirements
- R1: For x > 0 and |y·ln x| ≤ 12.4, result_o holds x^y within 5 % relative plus 1e-3 absolute error. All values are two's complement with value = integer / 2^FW, so 1.0 is 2^FW.
- R2: With x = 1.0, the result is 1.0 within the R1 tolerance for any y.
- R3: With y = 0, the result is 1.0 within the R1 tolerance for any valid x.
- R4: For a valid x, done_o is high exactly 2(M+1) + 2N + 2v(N) + 5 cycles after the cycle in which start_i was sampled. Here v(N) counts the repeated indices 4, 13, 40, … that are ≤ N, which gives 61 cycles for M=5 and N=20.
- R5: done_o is high for a single cycle per accepted start.
- R6: A start with x ≤ 0 gives done_o two cycles after the start cycle, with dom_err_o = 1 and result_o = 0.
- R7: start_i is ignored while an operation is in progress. Neither the running result nor its completion cycle changes.
- R8: result_o and dom_err_o hold their values from one done pulse until the next. A valid operation clears dom_err_o.
- R9: During and after reset, done_o, dom_err_o and result_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request pulse; sampled only when idle |
| x_i | input | B | Base operand, signed [B FW] |
| y_i | input | B | Exponent operand, signed [B FW] |
| inv_gain_i | input | B | Reciprocal of the engine gain, [B FW], sampled with start |
| done_o | output | 1 | One-cycle completion pulse |
| dom_err_o | output | 1 | Set when the base was not positive |
| result_o | output | B | x^y in [B FW], or 0 on a domain error |

## Verification
The bench builds the block as a 40-bit word with 20 fractional bits, M=5 and N=20. This gives a convergence bound of about 12.43 on y·ln x, leaves room for results up to roughly 5·10^5, and includes the repeated indices 4 and 13 in the schedule, for a 61-cycle operation. Within these limits the bench can sweep bases from 0.5 to 1000 and exponents of both signs. It can also reach the unit-base and zero-exponent corners, and it can hit an operation with a second start in the middle of its run.

// File: rtl/xpow_pkg.sv
// Shared types and elaboration-time helpers for the powering unit.
// Assumes B <= 64 and FW <= 54 (angle constants are built with 56 fraction bits).
package xpow_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOG_START,
        ST_LOG_WAIT,
        ST_MUL,
        ST_EXP_START,
        ST_EXP_WAIT,
        ST_OUT
    } xpow_state_e;

    localparam int ANG_P = 56;

    // Number of positive indices 4, 13, 40, ... that do not exceed n
    function automatic int rep_count(int n);
        int r;
        int c;
        r = 4;
        c = 0;
        for (int q = 0; q < 20; q++) begin
            if (r <= n) begin
                c++;
                r = 3 * r + 1;
            end
        end
        return c;
    endfunction

    // Total engine steps for one pass
    function automatic int step_count(int m, int n);
        return m + 1 + n + rep_count(n);
    endfunction

    // Largest shift distance used by the schedule
    function automatic int max_shift(int m, int n);
        return (m + 2 > n) ? m + 2 : n;
    endfunction

    // Iteration index executed at step s (non-positive first, repeats doubled)
    function automatic int sched_idx(int s, int m, int n);
        int pos;
        int rep;
        int res;
        res = 1;
        if (s <= m) return s - m;
        pos = m + 1;
        rep = 4;
        for (int i = 1; i <= n; i++) begin
            if (pos == s) res = i;
            pos++;
            if (i == rep) begin
                if (pos == s) res = i;
                pos++;
                rep = 3 * rep + 1;
            end
        end
        return res;
    endfunction

    // Rotation angle of index i, rounded to fw fraction bits
    function automatic logic [63:0] atanh_fx(int i, int fw);
        logic [63:0] one;
        logic [63:0] pw;
        logic [63:0] lsum;
        logic [63:0] ln2;
        logic [63:0] acc;
        int sh;
        int u;
        one  = 64'd1 << ANG_P;
        pw   = one / 64'd3;
        lsum = '0;
        for (int k = 0; k < 40; k++) begin
            lsum = lsum + pw / 64'(2 * k + 1);
            pw   = pw / 64'd9;
        end
        ln2 = lsum << 1;
        acc = '0;
        if (i > 0) begin
            for (int k = 0; k < 32; k++) begin
                sh = i * (2 * k + 1);
                if (sh < 60) acc = acc + (one >> sh) / 64'(2 * k + 1);
            end
        end else begin
            u   = 3 - i;
            acc = 64'(u) * ln2;
            for (int j = 1; j < 64; j++) begin
                sh = j * u;
                if (sh < 60) acc = acc - (one >> sh) / 64'(j);
            end
            acc = acc >> 1;
        end
        return (acc + (64'd1 << (ANG_P - fw - 1))) >> (ANG_P - fw);
    endfunction

endpackage

// File: rtl/xpow_steps.sv
// Per-step schedule lookup: shift distance, step kind and angle constant.
// All tables are built at elaboration from M, N and FW; assumes B <= 64.
module xpow_steps
    import xpow_pkg::*;
#(
    parameter int B  = 40,
    parameter int FW = 20,
    parameter int M  = 5,
    parameter int N  = 20,
    localparam int STEPS = step_count(M, N),
    localparam int CW    = $clog2(STEPS),
    localparam int SHW   = $clog2(max_shift(M, N) + 1)
) (
    input  logic [CW-1:0]  step_i,
    output logic [SHW-1:0] shift_o,
    output logic           neg_o,
    output logic [B-1:0]   angle_o
);

    logic [SHW-1:0]   sh_tab  [STEPS];
    logic [B-1:0]     ang_tab [STEPS];
    logic [STEPS-1:0] neg_vec;

    // One table entry per step of the schedule
    for (genvar g = 0; g < STEPS; g++) begin : g_step
        localparam int          IDX = sched_idx(g, M, N);
        localparam logic [63:0] ANG = atanh_fx(IDX, FW);
        assign sh_tab[g]  = SHW'((IDX <= 0) ? 2 - IDX : IDX);
        assign neg_vec[g] = (IDX <= 0);
        assign ang_tab[g] = ANG[B-1:0];
    end

    // Select the entry for the current step, zero beyond the schedule
    always_comb begin
        shift_o = '0;
        neg_o   = 1'b0;
        angle_o = '0;
        if (int'(step_i) < STEPS) begin
            shift_o = sh_tab[step_i];
            neg_o   = neg_vec[step_i];
            angle_o = ang_tab[step_i];
        end
    end

endmodule

// File: rtl/xpow_hcordic.sv
// Iterative hyperbolic rotation engine, one schedule step per cycle.
// start_i loads the operands; last_o is high in the cycle of the final step,
// after which x_o/y_o/z_o hold the converged values until the next load.
// Assumes the caller keeps operands inside the convergence range.
module xpow_hcordic
    import xpow_pkg::*;
#(
    parameter int B  = 40,
    parameter int FW = 20,
    parameter int M  = 5,
    parameter int N  = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                vect_i,
    input  logic signed [B-1:0] x_i,
    input  logic signed [B-1:0] y_i,
    input  logic signed [B-1:0] z_i,
    output logic                last_o,
    output logic signed [B-1:0] x_o,
    output logic signed [B-1:0] y_o,
    output logic signed [B-1:0] z_o
);

    localparam int STEPS = step_count(M, N);
    localparam int CW    = $clog2(STEPS);
    localparam int SHW   = $clog2(max_shift(M, N) + 1);

    logic signed [B-1:0] x_q, y_q, z_q;
    logic [CW-1:0]       cnt_q;
    logic                busy_q;
    logic                vect_q;

    logic [SHW-1:0]      sh;
    logic                neg;
    logic [B-1:0]        ang;
    logic signed [B-1:0] xs, ys, tx, ty, xn, yn, zn;
    logic                dneg;

    xpow_steps #(.B(B), .FW(FW), .M(M), .N(N)) steps_i (
        .step_i  (cnt_q),
        .shift_o (sh),
        .neg_o   (neg),
        .angle_o (ang)
    );

    // Next coordinates for the current step and direction
    always_comb begin
        xs   = x_q >>> sh;
        ys   = y_q >>> sh;
        tx   = neg ? x_q - xs : xs;
        ty   = neg ? y_q - ys : ys;
        dneg = vect_q ? (x_q[B-1] == y_q[B-1]) : z_q[B-1];
        if (dneg) begin
            xn = x_q - ty;
            yn = y_q - tx;
            zn = z_q + $signed(ang);
        end else begin
            xn = x_q + ty;
            yn = y_q + tx;
            zn = z_q - $signed(ang);
        end
    end

    // Load, step and stop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q    <= '0;
            y_q    <= '0;
            z_q    <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            vect_q <= 1'b0;
        end else if (start_i) begin
            x_q    <= x_i;
            y_q    <= y_i;
            z_q    <= z_i;
            cnt_q  <= '0;
            busy_q <= 1'b1;
            vect_q <= vect_i;
        end else if (busy_q) begin
            x_q <= xn;
            y_q <= yn;
            z_q <= zn;
            if (cnt_q == CW'(STEPS - 1)) busy_q <= 1'b0;
            else                         cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign last_o = busy_q && (cnt_q == CW'(STEPS - 1));
    assign x_o    = x_q;
    assign y_o    = y_q;
    assign z_o    = z_q;

    AST_VECT_XPOS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && vect_q) |-> !x_q[B-1]); // R1
    AST_LAST_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> !last_o); // R4

endmodule

// File: rtl/xpow_fxmul.sv
// Signed [B FW] multiplier: full product, FW low bits dropped, saturated to B bits.
module xpow_fxmul #(
    parameter int B  = 40,
    parameter int FW = 20
) (
    input  logic signed [B-1:0] a_i,
    input  logic signed [B-1:0] b_i,
    output logic signed [B-1:0] p_o
);

    localparam logic signed [B-1:0] P_MAX = {1'b0, {(B-1){1'b1}}};
    localparam logic signed [B-1:0] P_MIN = {1'b1, {(B-1){1'b0}}};

    logic signed [2*B-1:0] full;
    logic signed [2*B-1:0] shd;
    logic                  fits;

    // Product, rescale and clamp
    always_comb begin
        full = a_i * b_i;
        shd  = full >>> FW;
        fits = (shd[2*B-1:B-1] == '0) || (shd[2*B-1:B-1] == '1);
        if (fits)              p_o = shd[B-1:0];
        else if (shd[2*B-1])   p_o = P_MIN;
        else                   p_o = P_MAX;
    end

    // A zero operand must give a zero product
    always_comb begin
        if (a_i == '0 || b_i == '0) begin
            AST_MUL_ZERO: assert (p_o == '0); // R3
        end
    end

endmodule

// File: rtl/xpow_powering.sv
// Powering controller: ln pass, double-and-scale, exp pass, output register.
// Assumes x > 0 and |y*ln x| within the engine bound for valid results;
// inv_gain_i must be the reciprocal of the engine gain for this M and N.
module xpow_powering
    import xpow_pkg::*;
#(
    parameter int B  = 40,
    parameter int FW = 20,
    parameter int M  = 5,
    parameter int N  = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic signed [B-1:0] x_i,
    input  logic signed [B-1:0] y_i,
    input  logic signed [B-1:0] inv_gain_i,
    output logic                done_o,
    output logic                dom_err_o,
    output logic signed [B-1:0] result_o
);

    localparam int STEPS = step_count(M, N);
    localparam int LAT   = 2 * STEPS + 5;
    localparam int LCW   = $clog2(LAT + 2);
    localparam logic signed [B-1:0] FX_ONE = {{(B-FW-1){1'b0}}, 1'b1, {FW{1'b0}}};

    xpow_state_e         st_q, st_d;
    logic signed [B-1:0] xop_q, yop_q, gain_q, prod_q, res_q;
    logic                err_q, done_q, dom_q;

    logic                eng_start, eng_vect, eng_last;
    logic signed [B-1:0] eng_xi, eng_yi, eng_zi;
    logic signed [B-1:0] eng_x, eng_y, eng_z;
    logic signed [B-1:0] ln_x, mul_p;
    logic                accept, bad_x;

    assign accept = (st_q == ST_IDLE) && start_i;
    assign bad_x  = x_i[B-1] || (x_i == '0);

    // Engine control and operand select for the two passes
    always_comb begin
        eng_start = (st_q == ST_LOG_START) || (st_q == ST_EXP_START);
        eng_vect  = (st_q == ST_LOG_START);
        if (st_q == ST_EXP_START) begin
            eng_xi = gain_q;
            eng_yi = gain_q;
            eng_zi = prod_q;
        end else begin
            eng_xi = xop_q + FX_ONE;
            eng_yi = xop_q - FX_ONE;
            eng_zi = '0;
        end
    end

    xpow_hcordic #(.B(B), .FW(FW), .M(M), .N(N)) eng_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (eng_start),
        .vect_i  (eng_vect),
        .x_i     (eng_xi),
        .y_i     (eng_yi),
        .z_i     (eng_zi),
        .last_o  (eng_last),
        .x_o     (eng_x),
        .y_o     (eng_y),
        .z_o     (eng_z)
    );

    // Half-log from pass one doubled back to ln x
    assign ln_x = eng_z <<< 1;

    xpow_fxmul #(.B(B), .FW(FW)) mul_i (
        .a_i (yop_q),
        .b_i (ln_x),
        .p_o (mul_p)
    );

    // Sequencer next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:      if (start_i) st_d = bad_x ? ST_OUT : ST_LOG_START;
            ST_LOG_START: st_d = ST_LOG_WAIT;
            ST_LOG_WAIT:  if (eng_last) st_d = ST_MUL;
            ST_MUL:       st_d = ST_EXP_START;
            ST_EXP_START: st_d = ST_EXP_WAIT;
            ST_EXP_WAIT:  if (eng_last) st_d = ST_OUT;
            ST_OUT:       st_d = ST_IDLE;
            default:      st_d = ST_IDLE;
        endcase
    end

    // State, operand capture, product and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            xop_q  <= '0;
            yop_q  <= '0;
            gain_q <= '0;
            prod_q <= '0;
            err_q  <= 1'b0;
            res_q  <= '0;
            done_q <= 1'b0;
            dom_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            done_q <= 1'b0;
            if (accept) begin
                xop_q  <= x_i;
                yop_q  <= y_i;
                gain_q <= inv_gain_i;
                err_q  <= bad_x;
            end
            if (st_q == ST_MUL) prod_q <= mul_p;
            if (st_q == ST_OUT) begin
                done_q <= 1'b1;
                dom_q  <= err_q;
                res_q  <= err_q ? '0 : eng_x;
            end
        end
    end

    assign done_o    = done_q;
    assign dom_err_o = dom_q;
    assign result_o  = res_q;

    // Cycle count since the accepted start, for the latency property
    logic [LCW-1:0] lat_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)      lat_cnt <= '0;
        else if (accept) lat_cnt <= LCW'(1);
        else             lat_cnt <= lat_cnt + 1'b1;
    end

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !dom_err_o) |-> (lat_cnt == LCW'(LAT))); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R5
    AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        dom_err_o |-> (result_o == '0)); // R6
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE && st_q != ST_OUT) |=> (st_q != ST_IDLE)); // R7

endmodule

// File: tb/xpow_powering_tb.sv
`timescale 1ns/1ps
module xpow_powering_tb_top;

    localparam int B   = 40;
    localparam int FW  = 20;
    localparam int M   = 5;
    localparam int N   = 20;
    localparam int LAT = 61;   // 2(M+1)+2N+2v(N)+5 with v(20)=2
    localparam int NV  = 10;
    // operands in units of 1/256
    localparam int XV [NV] = '{512, 2560, 128, 768, 25600, 384, 1792, 128, 12800, 256000};
    localparam int YV [NV] = '{768,  640, 1024, -512, 384, 128, 1024, -768, 768, 256};

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start_i = 1'b0;
    logic signed [B-1:0] x_i = '0;
    logic signed [B-1:0] y_i = '0;
    logic signed [B-1:0] inv_gain_i = '0;
    logic                done_o;
    logic                dom_err_o;
    logic signed [B-1:0] result_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    xpow_powering #(.B(B), .FW(FW), .M(M), .N(N)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .x_i        (x_i),
        .y_i        (y_i),
        .inv_gain_i (inv_gain_i),
        .done_o     (done_o),
        .dom_err_o  (dom_err_o),
        .result_o   (result_o)
    );

    task automatic chk(input bit ok, input string tag, input string what);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", tag, what);
        end
    endtask

    function automatic real to_r(input logic signed [B-1:0] v);
        return real'(v) / 1048576.0;
    endfunction

    function automatic logic signed [B-1:0] fx256(input int v);
        logic signed [B-1:0] t;
        t = B'(v);
        return t <<< (FW - 8);
    endfunction

    function automatic bit close(input real got, input real exp);
        real d;
        real e;
        d = (got > exp) ? got - exp : exp - got;
        e = (exp < 0.0) ? -exp : exp;
        return d <= 0.05 * e + 1.0e-3;
    endfunction

    // Engine gain from the schedule: k=2..M+2, then 1..N with 4 and 13 doubled
    function automatic real inv_gain_r();
        real a;
        real t;
        real f;
        a = 1.0;
        for (int k = 2; k <= M + 2; k++) begin
            t = 1.0 - 2.0 ** (-k);
            a = a * $sqrt(1.0 - t * t);
        end
        for (int i = 1; i <= N; i++) begin
            f = $sqrt(1.0 - 2.0 ** (-2 * i));
            a = a * f;
            if (i == 4 || i == 13) a = a * f;
        end
        return 1.0 / a;
    endfunction

    // One request; optional second start at cycle poke_at with base poke_x
    task automatic run_op(input logic signed [B-1:0] xv, input logic signed [B-1:0] yv,
                          input int poke_at, input logic signed [B-1:0] poke_x,
                          output logic signed [B-1:0] res, output bit err,
                          output int lat, output bit pulse_ok);
        @(negedge clk);
        x_i = xv;
        y_i = yv;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        while (!done_o && lat < 400) begin
            if (poke_at != 0 && lat == poke_at) begin
                start_i = 1'b1;
                x_i = poke_x;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start_i = 1'b0;
        res = result_o;
        err = dom_err_o;
        @(negedge clk);
        pulse_ok = !done_o;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic signed [B-1:0] res;
        bit   err;
        bit   pok;
        int   lat;
        real  exp_v;

        inv_gain_i = B'(longint'(inv_gain_r() * 1048576.0));
        repeat (3) @(negedge clk);
        // R9: reset values
        chk(done_o == 1'b0 && dom_err_o == 1'b0 && result_o == '0, "R9",
            $sformatf("reset done=%0b err=%0b res=%0d expected 0/0/0", done_o, dom_err_o, result_o));
        rst_n = 1'b1;
        @(negedge clk);
        chk(done_o == 1'b0 && result_o == '0, "R9",
            $sformatf("after reset done=%0b res=%0d expected 0/0", done_o, result_o));

        // R1 R4 R5: vector sweep
        for (int v = 0; v < NV; v++) begin
            run_op(fx256(XV[v]), fx256(YV[v]), 0, '0, res, err, lat, pok);
            exp_v = $pow(real'(XV[v]) / 256.0, real'(YV[v]) / 256.0);
            chk(close(to_r(res), exp_v) && !err, "R1",
                $sformatf("vec %0d got %f err=%0b expected %f", v, to_r(res), err, exp_v));
            chk(lat == LAT, "R4", $sformatf("vec %0d latency %0d expected %0d", v, lat, LAT));
            chk(pok, "R5", $sformatf("vec %0d done high %0d expected 0 after pulse", v, !pok));
        end

        // R2: unit base
        run_op(fx256(256), fx256(640), 0, '0, res, err, lat, pok);
        chk(close(to_r(res), 1.0), "R2", $sformatf("1^2.5 got %f expected 1.0", to_r(res)));
        run_op(fx256(256), fx256(-1280), 0, '0, res, err, lat, pok);
        chk(close(to_r(res), 1.0), "R2", $sformatf("1^-5 got %f expected 1.0", to_r(res)));

        // R3: zero exponent
        run_op(fx256(1280), fx256(0), 0, '0, res, err, lat, pok);
        chk(close(to_r(res), 1.0), "R3", $sformatf("5^0 got %f expected 1.0", to_r(res)));
        run_op(fx256(128000), fx256(0), 0, '0, res, err, lat, pok);
        chk(close(to_r(res), 1.0), "R3", $sformatf("500^0 got %f expected 1.0", to_r(res)));

        // R6: non-positive base
        run_op(fx256(0), fx256(512), 0, '0, res, err, lat, pok);
        chk(err && res == '0 && lat == 2, "R6",
            $sformatf("x=0 err=%0b res=%0d lat=%0d expected 1/0/2", err, res, lat));
        chk(pok, "R5", "error done pulse longer than one cycle, expected 0");
        // R8: error result holds
        repeat (4) @(negedge clk);
        chk(dom_err_o && result_o == '0, "R8",
            $sformatf("hold err=%0b res=%0d expected 1/0", dom_err_o, result_o));
        run_op(fx256(-768), fx256(512), 0, '0, res, err, lat, pok);
        chk(err && res == '0 && lat == 2, "R6",
            $sformatf("x=-3 err=%0b res=%0d lat=%0d expected 1/0/2", err, res, lat));

        // R8: valid op clears the flag and its result holds
        run_op(fx256(1024), fx256(384), 0, '0, res, err, lat, pok);
        chk(!err && close(to_r(res), 8.0), "R8",
            $sformatf("4^1.5 err=%0b got %f expected 0/8.0", err, to_r(res)));
        repeat (5) @(negedge clk);
        chk(result_o == res && !dom_err_o, "R8",
            $sformatf("hold res=%0d err=%0b expected %0d/0", result_o, dom_err_o, res));

        // R7: start during an operation is ignored
        run_op(fx256(1024), fx256(384), 10, fx256(-256), res, err, lat, pok);
        chk(!err && close(to_r(res), 8.0) && lat == LAT, "R7",
            $sformatf("poked run err=%0b got %f lat %0d expected 0/8.0/%0d", err, to_r(res), lat, LAT));
        run_op(fx256(2560), fx256(512), 40, fx256(512), res, err, lat, pok);
        chk(!err && close(to_r(res), 100.0) && lat == LAT, "R7",
            $sformatf("poked run err=%0b got %f lat %0d expected 0/100.0/%0d", err, to_r(res), lat, LAT));

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule